// File: doc/BRIEF.md
# DMA Byte Realignment Engine

This block sits in the data path of a DMA copy between a 32-bit source and a 32-bit destination whose byte addresses may have different offsets within a word. Every source read is a whole 32-bit word. The block keeps only the bytes that belong to the transfer and moves them into the lanes that match the destination address. It emits aligned words together with byte enables.

A transfer starts with a one-cycle `start` pulse. The pulse carries the source byte offset, the destination byte offset and the byte count. Source words arrive on a valid/ready stream. Aligned words leave on a second valid/ready stream with per-lane enables and a last-word flag. Leftover bytes wait in a holding register until they can complete an output word. When the count is used up, the final partial word goes out without any further source input.

Top module: `dma_realign`

## Requirements
- R1: In the first source word, byte lanes below the source offset are discarded; in the final source word, lanes beyond the byte count are discarded.
- R2: After `start`, exactly ceil((source offset + count)/4) source words are accepted, and `s_ready` stays low while idle.
- R3: Transfer byte j appears in output lane (destination offset + j) mod 4 of output word (destination offset + j) div 4; lanes whose enable is off read zero.
- R4: The first output word enables lanes from the destination offset upward, and no lane below it.
- R5: The last output word enables exactly the lanes still holding transfer bytes, and no others.
- R6: A transfer that fits inside one destination word uses the intersection of the first-word and last-word masks.
- R7: Every output word that is neither first nor last has all four enables set (4'hF).
- R8: `m_last` is high only on the final output word, and that word is emitted even though no further source word arrives.
- R9: `m_valid` stays low until a word is complete. Once raised, `m_valid`, `m_data` and `m_be` hold unchanged until `m_ready` is high.
- R10: A `start` pulse while a transfer is in progress is ignored. A `start` pulse with a zero count starts nothing.
- R11: After reset, `m_valid` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer using src_off, dst_off and len |
| src_off | input | 2 | Byte offset of the first source byte within its word |
| dst_off | input | 2 | Byte offset of the first destination byte within its word |
| len | input | LEN_W | Transfer length in bytes |
| s_valid | input | 1 | Source word valid |
| s_ready | output | 1 | Source word accepted this cycle |
| s_data | input | 32 | Source word, lane 0 in bits 7:0 |
| m_valid | output | 1 | Aligned word valid |
| m_ready | input | 1 | Destination accepts the word |
| m_data | output | 32 | Aligned word, lane 0 in bits 7:0 |
| m_be | output | 4 | Byte enables, bit i for lane i |
| m_last | output | 1 | Final word of the transfer |

## Verification
The bench runs every pairing of source and destination offsets, with lengths from one byte up to several words. It fills the unused lanes of the source words with junk. A design that failed to discard those lanes would leak junk into the output data, and a wrong shift would put bytes into the wrong lanes. Single-byte and sub-word lengths check the combined edge mask: a design that used only one of the two masks would enable lanes past the end. The bench applies random stalls on both streams. Under these stalls, a design that changed its held word, or signalled a word before enough bytes had arrived, would fail the comparison. The bench also sends stray `start` pulses during a transfer and a zero-length start. Honouring either would corrupt or lengthen the expected stream.

// File: rtl/dma_realign.sv
module dma_realign #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       src_off,
  input  logic [1:0]       dst_off,
  input  logic [LEN_W-1:0] len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [31:0]      s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [31:0]      m_data,
  output logic [3:0]       m_be,
  output logic             m_last
);
  localparam int HOLD_W = 64;

  logic             busy, first_src, first_dst;
  logic [1:0]       soff_q, doff_q;
  logic [LEN_W-1:0] src_rem, out_rem;
  logic [2:0]       cnt;
  logic [HOLD_W-1:0] hold;

  logic [2:0] src_room, out_room, src_take, out_take, pop, cnt_mid;
  logic [1:0] lane0, rd_sh;
  logic       acc_s, acc_m;
  logic [7:0] be_wide;
  logic [31:0] raw, be_mask, word_sh, word_keep;
  logic [HOLD_W-1:0] keep_mask, hold_n;

  assign src_room = first_src ? 3'(3'd4 - {1'b0, soff_q}) : 3'd4;
  assign out_room = first_dst ? 3'(3'd4 - {1'b0, doff_q}) : 3'd4;
  assign src_take = (src_rem < LEN_W'(src_room)) ? src_rem[2:0] : src_room;
  assign out_take = (out_rem < LEN_W'(out_room)) ? out_rem[2:0] : out_room;
  assign lane0    = first_dst ? doff_q : 2'd0;
  assign rd_sh    = first_src ? soff_q : 2'd0;

  assign m_valid = busy && (cnt >= out_take);
  assign m_last  = (out_rem == LEN_W'(out_take));
  assign s_ready = busy && (src_rem != '0) && (cnt <= 3'd3);
  assign acc_s   = s_valid && s_ready;
  assign acc_m   = m_valid && m_ready;

  assign be_wide = ((8'd1 << out_take) - 8'd1) << lane0;
  assign m_be    = be_wide[3:0];
  assign raw     = hold[31:0] << {lane0, 3'b000};

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign be_mask[8*i +: 8] = {8{m_be[i]}};
  end
  assign m_data = raw & be_mask;

  assign word_sh   = s_data >> {rd_sh, 3'b000};
  assign keep_mask = (64'd1 << {src_take, 3'b000}) - 64'd1;
  assign word_keep = word_sh & keep_mask[31:0];

  assign pop     = acc_m ? out_take : 3'd0;
  assign cnt_mid = cnt - pop;
  assign hold_n  = (hold >> {pop, 3'b000})
                 | (acc_s ? ({32'b0, word_keep} << {cnt_mid, 3'b000}) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      first_src <= 1'b0;
      first_dst <= 1'b0;
      soff_q    <= '0;
      doff_q    <= '0;
      src_rem   <= '0;
      out_rem   <= '0;
      cnt       <= '0;
      hold      <= '0;
    end else if (!busy) begin
      if (start && len != '0) begin
        busy      <= 1'b1;
        first_src <= 1'b1;
        first_dst <= 1'b1;
        soff_q    <= src_off;
        doff_q    <= dst_off;
        src_rem   <= len;
        out_rem   <= len;
        cnt       <= '0;
        hold      <= '0;
      end
    end else begin
      hold <= hold_n;
      cnt  <= cnt_mid + (acc_s ? src_take : 3'd0);
      if (acc_s) begin
        first_src <= 1'b0;
        src_rem   <= src_rem - LEN_W'(src_take);
      end
      if (acc_m) begin
        first_dst <= 1'b0;
        out_rem   <= out_rem - LEN_W'(out_take);
        if (m_last) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_realign_chk.sv
module dma_realign_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       dst_off,
  input logic [LEN_W-1:0] len,
  input logic             busy,
  input logic             s_ready,
  input logic             m_valid,
  input logic             m_ready,
  input logic [31:0]      m_data,
  input logic [3:0]       m_be,
  input logic             m_last
);
  logic       exp_first;
  logic [1:0] dq;
  logic [3:0] low_mask, lane_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_first <= 1'b0;
      dq        <= '0;
    end else if (!busy && start && len != '0) begin
      exp_first <= 1'b1;
      dq        <= dst_off;
    end else if (m_valid && m_ready) begin
      exp_first <= 1'b0;
    end
  end

  assign low_mask = (4'd1 << dq) - 4'd1;
  for (genvar i = 0; i < 4; i++) begin : g_lm
    assign lane_mask[i] = (m_data[8*i +: 8] != 8'd0);
  end

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !s_ready); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !m_valid); // R10
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_be) && $stable(m_last)); // R9
  AST_FIRST_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && exp_first |-> m_be[dq] && ((m_be & low_mask) == 4'd0)); // R4
  AST_MID_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !exp_first && !m_last |-> m_be == 4'hF); // R7
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> m_be != 4'd0); // R5
  AST_DEAD_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (lane_mask & ~m_be) == 4'd0); // R3
endmodule

bind dma_realign dma_realign_chk #(.LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .dst_off(dst_off), .len(len),
  .busy(busy), .s_ready(s_ready), .m_valid(m_valid), .m_ready(m_ready),
  .m_data(m_data), .m_be(m_be), .m_last(m_last)
);

// File: tb/dma_realign_tb_top.sv
module dma_realign_tb_top;
  localparam int LEN_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] src_off = '0, dst_off = '0;
  logic [LEN_W-1:0] len = '0;
  logic s_valid = 1'b0, m_ready = 1'b0;
  logic [31:0] s_data = '0;
  logic s_ready, m_valid, m_last;
  logic [31:0] m_data;
  logic [3:0] m_be;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] src_q[$], exp_d[$];
  logic [3:0]  exp_b[$];
  logic        exp_l[$];
  int          exp_w[$];
  int          exp_n;

  always #2.5 clk = ~clk;

  dma_realign #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .src_off(src_off), .dst_off(dst_off),
    .len(len), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_be(m_be), .m_last(m_last)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic build(input int so, input int dof, input int n, input int tag);
    int nw = (dof + n + 3) / 4;
    int ns = (so + n + 3) / 4;
    logic [31:0] d;
    logic [3:0] b;
    for (int w = 0; w < ns; w++) src_q.push_back({8'hE0 + 8'(w), 8'hD1, 8'hC2, 8'hB3});
    for (int j = 0; j < n; j++) begin
      int p = so + j;
      src_q[p/4][8*(p%4) +: 8] = 8'(j * 7 + tag + 1);
    end
    exp_n = nw;
    for (int w = 0; w < nw; w++) begin
      d = '0; b = '0;
      for (int j = 0; j < n; j++) begin
        int p = dof + j;
        if (p / 4 == w) begin
          d[8*(p%4) +: 8] = 8'(j * 7 + tag + 1);
          b[p%4] = 1'b1;
        end
      end
      exp_d.push_back(d); exp_b.push_back(b); exp_l.push_back(w == nw - 1); exp_w.push_back(w);
    end
  endtask

  task automatic feed(input bit stray);
    int sent = 0;
    while (src_q.size() > 0) begin
      @(negedge clk);
      start = 1'b0;
      if ($urandom % 4 == 0) begin
        s_valid = 1'b0;
        continue;
      end
      s_valid = 1'b1;
      s_data = src_q[0];
      #1;
      if (s_ready) begin
        void'(src_q.pop_front());
        sent++;
        if (stray && sent == 1) begin
          @(negedge clk);
          s_valid = 1'b0;
          start = 1'b1; src_off = 2'd3; dst_off = 2'd1; len = 16'd2; // R10 stray start
        end
      end
    end
    @(negedge clk);
    s_valid = 1'b0;
    start = 1'b0;
  endtask

  task automatic drain();
    bit held = 0;
    logic [31:0] hd;
    logic [3:0] hb;
    string rq;
    while (exp_d.size() > 0) begin
      @(negedge clk);
      m_ready = ($urandom % 3 != 0);
      #1;
      if (held && m_valid)
        chk(m_data == hd && m_be == hb, "R9 held word changed", {m_be, m_data[27:0]}, {hb, hd[27:0]});
      held = m_valid && !m_ready;
      hd = m_data; hb = m_be;
      if (m_valid && m_ready) begin
        int w = exp_w[0];
        chk(m_data == exp_d[0], "R3 R1 data", m_data, exp_d[0]);
        if (exp_n == 1) rq = "R6 single-word be";
        else if (w == 0) rq = "R4 first be";
        else if (w == exp_n - 1) rq = "R5 last be";
        else rq = "R7 middle be";
        chk(m_be == exp_b[0], rq, 32'(m_be), 32'(exp_b[0]));
        chk(m_last == exp_l[0], "R8 last flag", 32'(m_last), 32'(exp_l[0]));
        void'(exp_d.pop_front()); void'(exp_b.pop_front());
        void'(exp_l.pop_front()); void'(exp_w.pop_front());
      end
    end
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic run(input int so, input int dof, input int n, input int tag);
    build(so, dof, n, tag);
    @(negedge clk);
    src_off = 2'(so); dst_off = 2'(dof); len = LEN_W'(n); start = 1'b1;
    fork
      feed(n >= 9);
      drain();
    join
    repeat (2) @(negedge clk);
    #1;
    chk(!s_ready, "R2 no extra source reads", 32'(s_ready), 32'd0);
    chk(!m_valid, "R8 no word after last", 32'(m_valid), 32'd0);
  endtask

  initial begin
    int lens[8] = '{1, 2, 3, 4, 5, 7, 9, 14};
    int tag = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!m_valid && !s_ready, "R11 reset state", {30'd0, m_valid, s_ready}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    start = 1'b1; len = '0; src_off = 2'd1; dst_off = 2'd2;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      #1;
      chk(!m_valid && !s_ready, "R10 zero-length start", {30'd0, m_valid, s_ready}, 32'd0);
    end
    for (int so = 0; so < 4; so++)
      for (int dof = 0; dof < 4; dof++)
        for (int k = 0; k < 8; k++) begin
          run(so, dof, lens[k], tag);
          tag += 13;
        end
    run(1, 3, 31, 5);
    run(3, 0, 40, 9);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule